// File: doc/BRIEF.md
# Processor Debug Access Port

This block lets an external bus master inspect and steer a processor through two word-wide slave registers on a pipelined Wishbone bus. The first register is the control word. The second is the data window. A write to the control word picks one processor register and sets or clears a halt request. The same write can also pulse a core reset. A read of the control word returns the current selection and the handshake state, along with the interrupt-enable (GIE) and sleep flags of the processor.

An access to the data window reads or writes whichever register is currently selected. Reading any register therefore takes two bus cycles: a control write, then a data access. Fetching both program counters takes four single bus cycles.

The processor is stood in for by a small register-file model. Its lower half of registers belongs to supervisor mode and its upper half to user mode. While the model runs, it advances the program counter of the active mode. It stops when halted or asleep. The data window never stalls a running core, so a live register can be sampled without halting. The data window stalls only while a halt or resume is still in flight. A data write that reaches a running core is dropped.

Top module: `dbg_port`

## Requirements
- R1: After reset, ack and stall are low, the selection is register 0, no halt is requested, and the core runs. Every register reads 0 and a control read returns 0.
- R2: Each accepted bus cycle (cyc and stb high, stall low) is acknowledged by ack high in exactly the next clock and only then. Read data is valid with that ack.
- R3: A control write takes the register index from bits [4:0] and the halt request from bit 8. A control read returns both in those same positions. The reset request in bit 9 always reads back as 0.
- R4: The halted status in control bit 10 follows the halt request one clock later, both when halting and when resuming.
- R5: A data read returns the value that the selected register held in the clock the read was accepted.
- R6: A data write updates the selected register when the core is halted. A data write is ignored while the core runs.
- R7: The data window stalls only while the halt request and the halted status disagree. The data window never stalls a running core with no halt pending. The control word never stalls.
- R8: While running and not asleep, the core adds 1 each clock to the active program counter. The active counter is register 15 when GIE is 0 and register 31 when GIE is 1. A halted core holds all registers.
- R9: Control bit 11 reports GIE and control bit 12 reports sleep. These mirror bits 5 and 4 of the supervisor condition register, index 14.
- R10: A control write with bit 9 set clears every processor register to 0.
- R11: With the core halted, the supervisor and user program counters are read in four single bus cycles: select 15, read, select 31, read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe, one request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control word, 1 = data window |
| bus_wdata | input | DW | Write data |
| bus_stall | output | 1 | Request not taken this clock |
| bus_ack | output | 1 | Request completed |
| bus_rdata | output | DW | Read data, valid with ack |

## Verification
The assertions assume that the master holds each request until it is taken and raises stb only together with cyc. They also assume that no control write lands in the clock before a data write checked for being ignored, other than a core reset. The bench drives one request at a time from the falling edge and keeps it up until stall is low. It sweeps every register index with a per-index pattern computed in the bench. It issues a data access directly behind a halt command so the transition stall is exercised.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int CMD_HALT_BIT  = 8;
  localparam int CMD_RST_BIT   = 9;
  localparam int ST_HALTED_BIT = 10;
  localparam int ST_GIE_BIT    = 11;
  localparam int ST_SLEEP_BIT  = 12;
  localparam int CC_SLEEP_BIT  = 4;
  localparam int CC_GIE_BIT    = 5;
  localparam int STATUS_W      = 16;

  function automatic logic [STATUS_W-1:0] pack_status(
    input logic [7:0] sel, input logic halt_req, input logic halted,
    input logic gie, input logic sleep);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[7:0]          = sel;
    s[CMD_HALT_BIT] = halt_req;
    s[ST_HALTED_BIT] = halted;
    s[ST_GIE_BIT]   = gie;
    s[ST_SLEEP_BIT] = sleep;
    return s;
  endfunction

  function automatic int active_pc(input logic gie, input int nregs);
    return gie ? nregs - 1 : nregs / 2 - 1;
  endfunction
endpackage

// File: rtl/dbg_bus_ctl.sv
module dbg_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic stb,
  input  logic we,
  input  logic addr,
  input  logic halt_req,
  input  logic halted,
  output logic stall,
  output logic accept,
  output logic cmd_wr,
  output logic data_wr,
  output logic ack
);
  logic req;
  assign req     = cyc && stb;
  assign stall   = req && addr && (halt_req != halted);
  assign accept  = req && !stall;
  assign cmd_wr  = accept && we && !addr;
  assign data_wr = accept && we && addr;

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= accept;
  end
endmodule

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg #(
  parameter int RSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [RSEL_W-1:0] w_sel,
  input  logic              w_halt,
  input  logic              w_rst,
  output logic [RSEL_W-1:0] sel_q,
  output logic              halt_req,
  output logic              core_rst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      halt_req <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      core_rst <= cmd_wr && w_rst;
      if (cmd_wr) begin
        sel_q    <= w_sel;
        halt_req <= w_halt;
      end
    end
  end
endmodule

// File: rtl/dbg_core_model.sv
module dbg_core_model
  import dbg_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREGS  = 32,
  parameter int RSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              core_rst,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] sel,
  input  logic [DW-1:0]     wdata,
  output logic              halted,
  output logic              gie,
  output logic              sleep,
  output logic [DW-1:0]     sel_val,
  output logic [DW-1:0]     pc_sup,
  output logic [DW-1:0]     pc_usr
);
  localparam int HALF = NREGS / 2;
  localparam logic [RSEL_W-1:0] CC_IDX = RSEL_W'(HALF - 2);
  localparam logic [RSEL_W-1:0] PC_SUP = RSEL_W'(HALF - 1);
  localparam logic [RSEL_W-1:0] PC_USR = RSEL_W'(NREGS - 1);

  logic [DW-1:0] regs [NREGS];
  logic [RSEL_W-1:0] pc_idx;
  logic wr_ok, pc_adv;

  assign gie     = regs[CC_IDX][CC_GIE_BIT];
  assign sleep   = regs[CC_IDX][CC_SLEEP_BIT];
  assign pc_idx  = RSEL_W'(active_pc(gie, NREGS));
  assign wr_ok   = wr_en && halted;
  assign pc_adv  = !halted && !sleep;
  assign sel_val = regs[sel];
  assign pc_sup  = regs[PC_SUP];
  assign pc_usr  = regs[PC_USR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      halted <= halt_req;
      if (core_rst) begin
        for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (wr_ok) begin
        regs[sel] <= wdata;
      end else if (pc_adv) begin
        regs[pc_idx] <= regs[pc_idx] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_port.sv
module dbg_port
  import dbg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREGS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_stall,
  output logic          bus_ack,
  output logic [DW-1:0] bus_rdata
);
  localparam int RSEL_W = $clog2(NREGS);

  logic              acc, cmd_wr, data_wr;
  logic [RSEL_W-1:0] sel_q;
  logic              halt_req, core_rst, halted, gie, sleep;
  logic [DW-1:0]     sel_val, pc_sup, pc_usr, status_w;

  dbg_bus_ctl u_bus (
    .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .addr(bus_addr), .halt_req(halt_req), .halted(halted),
    .stall(bus_stall), .accept(acc), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .ack(bus_ack)
  );

  dbg_cmd_reg #(.RSEL_W(RSEL_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
    .w_sel(bus_wdata[RSEL_W-1:0]), .w_halt(bus_wdata[CMD_HALT_BIT]),
    .w_rst(bus_wdata[CMD_RST_BIT]),
    .sel_q(sel_q), .halt_req(halt_req), .core_rst(core_rst)
  );

  dbg_core_model #(.DW(DW), .NREGS(NREGS), .RSEL_W(RSEL_W)) u_core (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .core_rst(core_rst),
    .wr_en(data_wr), .sel(sel_q), .wdata(bus_wdata),
    .halted(halted), .gie(gie), .sleep(sleep), .sel_val(sel_val),
    .pc_sup(pc_sup), .pc_usr(pc_usr)
  );

  assign status_w = DW'(pack_status(8'(sel_q), halt_req, halted, gie, sleep));

  always_ff @(posedge clk) begin
    if (!rst_n)             bus_rdata <= '0;
    else if (acc && !bus_we) bus_rdata <= bus_addr ? sel_val : status_w;
  end
endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_stb,
  input logic          bus_addr,
  input logic          bus_stall,
  input logic          bus_ack,
  input logic          acc,
  input logic          data_wr,
  input logic          core_rst,
  input logic          halt_req,
  input logic          halted,
  input logic          gie,
  input logic [DW-1:0] sel_val,
  input logic [DW-1:0] pc_sup,
  input logic [DW-1:0] pc_usr
);
  logic live_safe;
  assign live_safe = data_wr && !halted && !core_rst;

  AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> bus_ack); // R2
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !bus_ack); // R2
  AST_NO_STALL_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && !halted) |-> !bus_stall); // R7
  AST_STALL_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> (bus_stb && bus_addr)); // R7
  AST_HALT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(halt_req)); // R4
  AST_FROZEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !data_wr && !core_rst) |=> ($stable(pc_sup) && $stable(pc_usr))); // R8
  AST_RUN_WRITE_DROPPED_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_safe && gie) |=> $stable(pc_sup)); // R6
  AST_RUN_WRITE_DROPPED_USR: assert property (@(posedge clk) disable iff (!rst_n)
    (live_safe && !gie && sel_val != pc_usr) |=> $stable(pc_usr)); // R6
endmodule

bind dbg_port dbg_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_addr(bus_addr),
  .bus_stall(bus_stall), .bus_ack(bus_ack), .acc(acc), .data_wr(data_wr),
  .core_rst(core_rst), .halt_req(halt_req), .halted(halted), .gie(gie),
  .sel_val(sel_val), .pc_sup(pc_sup), .pc_usr(pc_usr)
);

// File: tb/sim_dbg_port.sv
module sim_dbg_port;
  localparam int DW = 32;
  localparam int NREGS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_stall, bus_ack;
  logic [DW-1:0] bus_rdata;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dbg_port #(.DW(DW), .NREGS(NREGS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_stall(bus_stall), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'h0000_00A5;
  endfunction

  // control word expected: sel [4:0], halt 8, halted 10, gie 11, sleep 12
  function automatic logic [31:0] ctl(input int sel, input bit h, input bit hd,
                                      input bit g, input bit s);
    return 32'(sel) | (32'(h) << 8) | (32'(hd) << 10) | (32'(g) << 11) | (32'(s) << 12);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic a, input logic w, input logic [31:0] d,
                      output logic [31:0] q, output int stalls);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
    stalls = 0;
    #1;
    while (bus_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
    chk(bus_ack == 1'b1, "R2 ack one clock after accept", 32'(bus_ack), 32'd1);
    q = bus_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    logic [31:0] q; int s;
    xfer(a, 1'b1, d, q, s);
  endtask

  task automatic rd(input logic a, output logic [31:0] q, output int s);
    xfer(a, 1'b0, 32'd0, q, s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q, v1, v2, cc;
    int s;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(bus_ack == 1'b0 && bus_stall == 1'b0, "R1 ack/stall low", {bus_ack, bus_stall}, 0);
    rd(1'b0, q, s);
    chk(q == 32'd0, "R1 control reads zero", q, 0);
    rd(1'b1, q, s);
    chk(q == 32'd0, "R1 register 0 reads zero", q, 0);
    idle(1);
    chk(bus_ack == 1'b0, "R2 ack lasts one clock", 32'(bus_ack), 0);

    // R7 stall while halt is in flight, then R4 halted status
    wr(1'b0, ctl(0, 1, 0, 0, 0));
    rd(1'b1, q, s);
    chk(s == 1, "R7 one stall during halt transition", 32'(s), 1);
    chk(q == 32'd0, "R5 read after stall", q, 0);
    rd(1'b0, q, s);
    chk(q == ctl(0, 1, 1, 0, 0), "R4 halted bit set", q, ctl(0, 1, 1, 0, 0));
    chk(s == 0, "R7 control never stalls", 32'(s), 0);

    // R6 writes while halted, R3 control readback, R5 readback sweep
    for (int i = 0; i < NREGS; i++) begin
      wr(1'b0, ctl(i, 1, 0, 0, 0));
      wr(1'b1, pat(i));
      rd(1'b0, q, s);
      chk(q == ctl(i, 1, 1, 0, 0) || i >= 14,
          "R3 select/halt fields", q, ctl(i, 1, 1, 0, 0));
    end
    for (int i = 0; i < NREGS; i++) begin
      wr(1'b0, ctl(i, 1, 0, 0, 0));
      rd(1'b1, q, s);
      chk(q == pat(i), "R6 R5 halted write then read", q, pat(i));
    end

    // R9 status mirrors condition register bits 5 and 4
    cc = pat(14);
    rd(1'b0, q, s);
    chk(q == ctl(31, 1, 1, cc[5], cc[4]), "R9 gie/sleep status", q,
        ctl(31, 1, 1, cc[5], cc[4]));

    // R11 both program counters in four single cycles
    wr(1'b0, ctl(15, 1, 0, 0, 0));
    rd(1'b1, v1, s);
    wr(1'b0, ctl(31, 1, 0, 0, 0));
    rd(1'b1, v2, s);
    chk(v1 == pat(15), "R11 supervisor pc", v1, pat(15));
    chk(v2 == pat(31), "R11 user pc", v2, pat(31));

    // R6 write dropped while running, R7 no stall
    wr(1'b0, ctl(3, 0, 0, 0, 0));
    idle(2);
    xfer(1'b1, 1'b1, 32'hDEAD_BEEF, q, s);
    chk(s == 0, "R7 no stall when running (write)", 32'(s), 0);
    rd(1'b1, q, s);
    chk(q == pat(3), "R6 running write ignored", q, pat(3));
    chk(s == 0, "R7 no stall when running (read)", 32'(s), 0);

    // R8 live user pc advances by one per clock (gie from pattern)
    wr(1'b0, ctl(31, 0, 0, 0, 0));
    rd(1'b1, v1, s);
    rd(1'b1, v2, s);
    chk(v2 == v1 + 32'd1, "R8 live pc advances", v2, v1 + 32'd1);
    chk(s == 0, "R7 live read no stall", 32'(s), 0);
    wr(1'b0, ctl(15, 0, 0, 0, 0));
    rd(1'b1, v1, s);
    rd(1'b1, v2, s);
    chk(v1 == pat(15) && v2 == pat(15), "R8 inactive pc holds", v2, pat(15));

    // R8 R9 sleep stops the core
    wr(1'b0, ctl(14, 1, 0, 0, 0));
    idle(2);
    wr(1'b1, cc | 32'h10);
    wr(1'b0, ctl(31, 0, 0, 0, 0));
    idle(2);
    rd(1'b0, q, s);
    chk(q == ctl(31, 0, 0, cc[5], 1), "R9 sleep status", q, ctl(31, 0, 0, cc[5], 1));
    rd(1'b1, v1, s);
    idle(3);
    rd(1'b1, v2, s);
    chk(v1 == v2, "R8 asleep pc frozen", v2, v1);

    // R10 core reset clears registers; R3 reset bit reads zero
    wr(1'b0, 32'h200 | ctl(5, 0, 0, 0, 0));
    idle(2);
    rd(1'b1, q, s);
    chk(q == 32'd0, "R10 register cleared", q, 0);
    rd(1'b0, q, s);
    chk(q == ctl(5, 0, 0, 0, 0), "R3 reset bit reads zero", q, ctl(5, 0, 0, 0, 0));
    idle(1);
    chk(bus_ack == 1'b0, "R2 no ack when idle", 32'(bus_ack), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule